// File: doc/BRIEF.md
# PCI Bridge Target Address Decoder

This block sits on the target side of a bridge between PCI and a slower expansion bus. At the start of every PCI cycle it classifies the address and command and decides whether the bridge claims the cycle, and by which method. The four outcomes are positive (claimed at once), negative (claimed one slot later, for addresses known not to belong to PCI), subtractive (claimed last, and only if no other agent answered) and not claimed. Both memory and I/O commands are handled. Configuration cycles addressed to the bridge are always taken positively.

The decision draws on values that software programs elsewhere and that reach this block as plain input pins. These are the top of main memory, a memory hole, four programmable subtractive regions, and read and write enables for each 16 KB segment of the 640 KB–1 MB area. There are also a global negative-decode enable, a relocatable BIOS timer register decode, and enables for the interrupt-controller and disk compatibility I/O ranges. The compatibility I/O ranges are also broadcast to the expansion bus. Such a cycle must be retried when the expansion bus belongs to another master or to DMA.

The result is latched once, on the clock edge that first samples FRAME asserted. It then drives DEVSEL in the slot that fits its class, and stays fixed until the transaction ends. The block has no data path and no handshake. All of its pins are plain control and status levels.

Top module: `pci_tgt_decode`

## Requirements
- R1: A configuration command (cmd 1010 or 1011) with `idsel_i` high is claimed positive. Without `idsel_i` it is not claimed. Claim encoding on `claim_o`: 0 none, 1 positive, 2 negative, 3 subtractive.
- R2: Memory commands are 0110, 1100 and 1110 (reads) and 0111 and 1111 (writes). The area 0xA0000–0xFFFFF is split into 24 segments of 16 KB, and the index is (addr−0xA0000)>>14. A read with that segment's `seg_rd_en_i` bit set is claimed positive, and so is a write with its `seg_wr_en_i` bit set. This takes precedence over the regions.
- R3: A segment access whose attribute bit is clear is claimed negative when `neg_en_i`=1 and subtractive when `neg_en_i`=0, unless a region matches it.
- R4: Region k matches a memory address when `rgn_vld_i[k]`=1 and base ≤ addr[31:16] ≤ limit (16-bit fields packed at k*16). A match is claimed subtractive whatever `neg_en_i`, top of memory or the hole say. A region whose limit is below its base matches nothing.
- R5: Any other memory address with addr[31:16] ≥ `tom_i`, or inside the inclusive hole range, is claimed negative when `neg_en_i`=1 and subtractive when it is 0. The remaining memory addresses are not claimed.
- R6: An I/O command (0010 or 0011) with `bt_en_i`=1 and addr[15:2]=`bt_base_i`[15:2] is claimed positive and not broadcast. With `bt_en_i`=0 that address is claimed subtractive.
- R7: I/O addresses 0x20, 0x21, 0xA0 and 0xA1 (when `pic_en_i` is set) and 0x1F0–0x1F7, 0x3F6 and 0x3F7 (when `ide_en_i` is set) are claimed positive with `bcast_o`=1. Every other I/O address is claimed subtractive.
- R8: `retry_o` is high for the whole transaction when the latched claim is a broadcast and `ebus_busy_i` was high at the latching edge. Otherwise it is low.
- R9: The claim is latched on the first rising edge with `frame_i` high after it was low. It is held even if the address or command change, and it clears on the edge that samples `trn_end_i`. Other commands are not claimed.
- R10: `devsel_o` rises in the cycle after the latching edge for a positive claim, one cycle later for a negative claim, and two cycles later for a subtractive claim. It then stays high until the transaction ends.
- R11: A subtractive claim never drives `devsel_o` if `other_devsel_i` was sampled high on either of the two edges after the latching edge.
- R12: While reset is held, `claim_o`, `devsel_o`, `bcast_o` and `retry_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | active-low reset |
| frame_i | input | 1 | FRAME sampled asserted (active high) |
| trn_end_i | input | 1 | transaction end pulse |
| addr_i | input | 32 | PCI address |
| cmd_i | input | 4 | PCI command |
| idsel_i | input | 1 | configuration select for this bridge |
| other_devsel_i | input | 1 | DEVSEL driven by another agent |
| ebus_busy_i | input | 1 | expansion bus owned by another master or DMA |
| tom_i | input | 16 | top of main memory, 64 KB units |
| hole_base_i | input | 16 | hole start, 64 KB units, inclusive |
| hole_lim_i | input | 16 | hole end, 64 KB units, inclusive |
| rgn_base_i | input | 64 | four region bases, 64 KB units |
| rgn_lim_i | input | 64 | four region limits, 64 KB units |
| rgn_vld_i | input | 4 | region valid bits |
| seg_rd_en_i | input | 24 | per-segment read enables |
| seg_wr_en_i | input | 24 | per-segment write enables |
| neg_en_i | input | 1 | negative decode enable |
| bt_en_i | input | 1 | BIOS timer decode enable |
| bt_base_i | input | 16 | BIOS timer I/O base (bits 15:2 used) |
| pic_en_i | input | 1 | interrupt-controller range enable |
| ide_en_i | input | 1 | disk range enable |
| claim_o | output | 2 | latched claim class |
| devsel_o | output | 1 | DEVSEL drive from this bridge |
| bcast_o | output | 1 | latched claim is a broadcast |
| retry_o | output | 1 | broadcast must be retried |

## Verification
A wrong decode priority or a wrong range compare shows as a wrong `claim_o` one cycle after FRAME is sampled. It also shows as a `devsel_o` pattern that is wrong over the following three cycles. A slot counter that runs fast or slow moves the rise of `devsel_o` by one cycle. A lost record of another agent's DEVSEL shows up at the slow slot as a double claim. A latch that tracks the live address instead of the sampled one changes `claim_o` while the transaction is still open.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;

  typedef enum logic [1:0] {
    CLM_NONE = 2'd0,
    CLM_POS  = 2'd1,
    CLM_NEG  = 2'd2,
    CLM_SUB  = 2'd3
  } claim_e;

  typedef enum logic [1:0] {
    CK_OTHER,
    CK_IO,
    CK_MEM,
    CK_CFG
  } ckind_e;

  localparam logic [19:0] COMPAT_LO = 20'hA0000;
  localparam int unsigned COMPAT_SPAN = 32'h100000 - 32'hA0000;

  function automatic ckind_e cmd_kind(input logic [3:0] c);
    case (c)
      4'h2, 4'h3:                      cmd_kind = CK_IO;
      4'h6, 4'h7, 4'hC, 4'hE, 4'hF:    cmd_kind = CK_MEM;
      4'hA, 4'hB:                      cmd_kind = CK_CFG;
      default:                         cmd_kind = CK_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/pci_dec_rgn.sv
module pci_dec_rgn #(
  parameter int PGW = 16
) (
  input  logic [PGW-1:0] pg_i,
  input  logic [PGW-1:0] base_i,
  input  logic [PGW-1:0] lim_i,
  input  logic           vld_i,
  output logic           hit_o
);
  // inclusive window; limit below base leaves it empty
  assign hit_o = vld_i && (pg_i >= base_i) && (pg_i <= lim_i);
endmodule

// File: rtl/pci_dec_map.sv
module pci_dec_map
  import pci_dec_pkg::*;
#(
  parameter int NRGN   = 4,
  parameter int PG_SH  = 16,
  parameter int SEG_SH = 14,
  localparam int PGW   = 32 - PG_SH,
  localparam int NSEG  = COMPAT_SPAN >> SEG_SH
) (
  input  logic [31:0]        addr_i,
  input  logic [3:0]         cmd_i,
  input  logic               idsel_i,
  input  logic [PGW-1:0]     tom_i,
  input  logic [PGW-1:0]     hole_base_i,
  input  logic [PGW-1:0]     hole_lim_i,
  input  logic [NRGN*PGW-1:0] rgn_base_i,
  input  logic [NRGN*PGW-1:0] rgn_lim_i,
  input  logic [NRGN-1:0]    rgn_vld_i,
  input  logic [NSEG-1:0]    seg_rd_en_i,
  input  logic [NSEG-1:0]    seg_wr_en_i,
  input  logic               neg_en_i,
  input  logic               bt_en_i,
  input  logic [15:0]        bt_base_i,
  input  logic               pic_en_i,
  input  logic               ide_en_i,
  output claim_e             claim_o,
  output logic               bcast_o
);
  localparam int SEG_IW = $clog2(NSEG);

  ckind_e          kind;
  logic [PGW-1:0]  pg;
  logic [NRGN-1:0] rgn_hit;
  logic            rgn_any;
  logic            in_compat, seg_on, hole_hit, above_top;
  logic [19:0]     seg_off;
  logic [SEG_IW-1:0] seg_idx;
  logic [15:0]     io_a;
  logic            pic_hit, ide_hit, bt_hit;

  assign kind = cmd_kind(cmd_i);
  assign pg   = addr_i[31:PG_SH];

  for (genvar g = 0; g < NRGN; g++) begin : g_rgn
    pci_dec_rgn #(.PGW(PGW)) u_rgn (
      .pg_i  (pg),
      .base_i(rgn_base_i[g*PGW +: PGW]),
      .lim_i (rgn_lim_i[g*PGW +: PGW]),
      .vld_i (rgn_vld_i[g]),
      .hit_o (rgn_hit[g])
    );
  end
  assign rgn_any = |rgn_hit;

  assign in_compat = (addr_i[31:20] == 12'h000) && (addr_i[19:0] >= COMPAT_LO);
  assign seg_off   = addr_i[19:0] - COMPAT_LO;
  assign seg_idx   = seg_off[SEG_SH +: SEG_IW];
  assign seg_on    = cmd_i[0] ? seg_wr_en_i[seg_idx] : seg_rd_en_i[seg_idx];
  assign hole_hit  = (pg >= hole_base_i) && (pg <= hole_lim_i);
  assign above_top = pg >= tom_i;

  assign io_a    = addr_i[15:0];
  assign pic_hit = pic_en_i && ((io_a[15:1] == 15'h0010) || (io_a[15:1] == 15'h0050));
  assign ide_hit = ide_en_i && ((io_a[15:3] == 13'h003E) || (io_a[15:1] == 15'h01FB));
  assign bt_hit  = bt_en_i && (io_a[15:2] == bt_base_i[15:2]);

  always_comb begin
    claim_o = CLM_NONE;
    bcast_o = 1'b0;
    case (kind)
      CK_CFG: claim_o = idsel_i ? CLM_POS : CLM_NONE;
      CK_IO: begin
        if (pic_hit || ide_hit) begin
          claim_o = CLM_POS;
          bcast_o = 1'b1;
        end else if (bt_hit) begin
          claim_o = CLM_POS;
        end else begin
          claim_o = CLM_SUB;
        end
      end
      CK_MEM: begin
        if (in_compat && seg_on)                      claim_o = CLM_POS;
        else if (rgn_any)                             claim_o = CLM_SUB;
        else if (in_compat || above_top || hole_hit)  claim_o = neg_en_i ? CLM_NEG : CLM_SUB;
        else                                          claim_o = CLM_NONE;
      end
      default: claim_o = CLM_NONE;
    endcase
  end

  always_comb begin
    if (kind == CK_MEM && rgn_any && !(in_compat && seg_on))
      assert_rgn_sub_R4: assert (claim_o == CLM_SUB)
        else $error("region hit not subtractive");
    if (claim_o == CLM_NEG)
      assert_neg_gate_R5: assert (neg_en_i && kind == CK_MEM)
        else $error("negative claim without enable");
    if (bcast_o)
      assert_bcast_io_R7: assert (kind == CK_IO && (pic_en_i || ide_en_i))
        else $error("broadcast outside compat I/O");
  end

endmodule

// File: rtl/pci_dec_slot.sv
module pci_dec_slot
  import pci_dec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   trn_end_i,
  input  claim_e claim_d_i,
  input  logic   bcast_d_i,
  input  logic   ebus_busy_i,
  input  logic   other_devsel_i,
  output claim_e claim_o,
  output logic   bcast_o,
  output logic   retry_o,
  output logic   devsel_o
);
  localparam logic [1:0] SLOT_FAST = 2'd1;
  localparam logic [1:0] SLOT_MED  = 2'd2;
  localparam logic [1:0] SLOT_SLOW = 2'd3;

  logic       active;
  logic [1:0] cnt;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      seen    <= 1'b0;
      claim_o <= CLM_NONE;
      bcast_o <= 1'b0;
      retry_o <= 1'b0;
    end else if (trn_end_i) begin
      active  <= 1'b0;
      cnt     <= '0;
      seen    <= 1'b0;
      claim_o <= CLM_NONE;
      bcast_o <= 1'b0;
      retry_o <= 1'b0;
    end else if (start_i && !active) begin
      active  <= 1'b1;
      cnt     <= SLOT_FAST;
      seen    <= 1'b0;
      claim_o <= claim_d_i;
      bcast_o <= bcast_d_i;
      retry_o <= bcast_d_i && ebus_busy_i;
    end else if (active) begin
      if (cnt != SLOT_SLOW) cnt <= cnt + 2'd1;
      if (cnt != SLOT_SLOW && other_devsel_i) seen <= 1'b1;
    end
  end

  always_comb begin
    devsel_o = 1'b0;
    if (active) begin
      case (claim_o)
        CLM_POS: devsel_o = 1'b1;
        CLM_NEG: devsel_o = (cnt >= SLOT_MED);
        CLM_SUB: devsel_o = (cnt == SLOT_SLOW) && !seen;
        default: devsel_o = 1'b0;
      endcase
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(claim_o))
    else $error("claim changed mid transaction");

  assert_neg_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(devsel_o) && claim_o == CLM_NEG) |-> (cnt == SLOT_MED))
    else $error("negative claim outside medium slot");

  assert_keep_devsel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_o && !trn_end_i) |=> devsel_o)
    else $error("devsel dropped early");

  assert_sub_yield_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_o && claim_o == CLM_SUB) |-> !seen)
    else $error("subtractive claim after other agent");

  assert_retry_bcast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> (bcast_o && active))
    else $error("retry without broadcast");

endmodule

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_dec_pkg::*;
#(
  parameter int NRGN   = 4,
  parameter int PG_SH  = 16,
  parameter int SEG_SH = 14,
  localparam int PGW   = 32 - PG_SH,
  localparam int NSEG  = COMPAT_SPAN >> SEG_SH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_i,
  input  logic                trn_end_i,
  input  logic [31:0]         addr_i,
  input  logic [3:0]          cmd_i,
  input  logic                idsel_i,
  input  logic                other_devsel_i,
  input  logic                ebus_busy_i,
  input  logic [PGW-1:0]      tom_i,
  input  logic [PGW-1:0]      hole_base_i,
  input  logic [PGW-1:0]      hole_lim_i,
  input  logic [NRGN*PGW-1:0] rgn_base_i,
  input  logic [NRGN*PGW-1:0] rgn_lim_i,
  input  logic [NRGN-1:0]     rgn_vld_i,
  input  logic [NSEG-1:0]     seg_rd_en_i,
  input  logic [NSEG-1:0]     seg_wr_en_i,
  input  logic                neg_en_i,
  input  logic                bt_en_i,
  input  logic [15:0]         bt_base_i,
  input  logic                pic_en_i,
  input  logic                ide_en_i,
  output logic [1:0]          claim_o,
  output logic                devsel_o,
  output logic                bcast_o,
  output logic                retry_o
);
  logic   frame_q;
  logic   start;
  claim_e dec_claim, held_claim;
  logic   dec_bcast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b0;
    else        frame_q <= frame_i;
  end
  assign start = frame_i && !frame_q;

  pci_dec_map #(.NRGN(NRGN), .PG_SH(PG_SH), .SEG_SH(SEG_SH)) u_map (
    .addr_i      (addr_i),
    .cmd_i       (cmd_i),
    .idsel_i     (idsel_i),
    .tom_i       (tom_i),
    .hole_base_i (hole_base_i),
    .hole_lim_i  (hole_lim_i),
    .rgn_base_i  (rgn_base_i),
    .rgn_lim_i   (rgn_lim_i),
    .rgn_vld_i   (rgn_vld_i),
    .seg_rd_en_i (seg_rd_en_i),
    .seg_wr_en_i (seg_wr_en_i),
    .neg_en_i    (neg_en_i),
    .bt_en_i     (bt_en_i),
    .bt_base_i   (bt_base_i),
    .pic_en_i    (pic_en_i),
    .ide_en_i    (ide_en_i),
    .claim_o     (dec_claim),
    .bcast_o     (dec_bcast)
  );

  pci_dec_slot u_slot (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .trn_end_i      (trn_end_i),
    .claim_d_i      (dec_claim),
    .bcast_d_i      (dec_bcast),
    .ebus_busy_i    (ebus_busy_i),
    .other_devsel_i (other_devsel_i),
    .claim_o        (held_claim),
    .bcast_o        (bcast_o),
    .retry_o        (retry_o),
    .devsel_o       (devsel_o)
  );

  assign claim_o = held_claim;

  assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_o == 2'd0) |-> (!devsel_o && !retry_o && !bcast_o))
    else $error("outputs active without claim");

endmodule

// File: tb/pci_tgt_decode_bench.sv
`timescale 1ns/1ps
module pci_tgt_decode_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_i = 1'b0, trn_end_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [3:0]  cmd_i = '0;
  logic        idsel_i = 1'b0, other_devsel_i = 1'b0, ebus_busy_i = 1'b0;
  logic [15:0] tom_i = 16'h0100, hole_base_i = 16'h00E0, hole_lim_i = 16'h00EF;
  logic [63:0] rgn_base_i = {16'h0300, 16'h00E8, 16'h0050, 16'h0200};
  logic [63:0] rgn_lim_i  = {16'h02FF, 16'h00E8, 16'h0050, 16'h020F};
  logic [3:0]  rgn_vld_i = 4'hF;
  logic [23:0] seg_rd_en_i = 24'h000100, seg_wr_en_i = 24'h000000;
  logic        neg_en_i = 1'b1, bt_en_i = 1'b1;
  logic [15:0] bt_base_i = 16'h0078;
  logic        pic_en_i = 1'b1, ide_en_i = 1'b0;
  logic [1:0]  claim_o;
  logic        devsel_o, bcast_o, retry_o;

  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pci_tgt_decode u_pci_tgt_decode (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .trn_end_i(trn_end_i),
    .addr_i(addr_i), .cmd_i(cmd_i), .idsel_i(idsel_i),
    .other_devsel_i(other_devsel_i), .ebus_busy_i(ebus_busy_i),
    .tom_i(tom_i), .hole_base_i(hole_base_i), .hole_lim_i(hole_lim_i),
    .rgn_base_i(rgn_base_i), .rgn_lim_i(rgn_lim_i), .rgn_vld_i(rgn_vld_i),
    .seg_rd_en_i(seg_rd_en_i), .seg_wr_en_i(seg_wr_en_i),
    .neg_en_i(neg_en_i), .bt_en_i(bt_en_i), .bt_base_i(bt_base_i),
    .pic_en_i(pic_en_i), .ide_en_i(ide_en_i),
    .claim_o(claim_o), .devsel_o(devsel_o), .bcast_o(bcast_o), .retry_o(retry_o)
  );

  // entry: addr[39:8] cmd[7:4] idsel[3] claim[2:1] bcast[0]
  localparam int NV = 18;
  localparam logic [39:0] VEC [0:NV-1] = '{
    {32'h0000_0000, 4'hA, 1'b1, 2'd1, 1'b0},  // R1 config to bridge
    {32'h0000_0000, 4'hB, 1'b0, 2'd0, 1'b0},  // R1 config to other
    {32'h0040_0000, 4'h6, 1'b0, 2'd0, 1'b0},  // R5 main memory
    {32'h0100_0000, 4'h6, 1'b0, 2'd2, 1'b0},  // R5 at top of memory
    {32'h00E1_0000, 4'h7, 1'b0, 2'd2, 1'b0},  // R5 hole
    {32'h0205_0000, 4'h6, 1'b0, 2'd3, 1'b0},  // R4 region 0 above top
    {32'h0050_0000, 4'h6, 1'b0, 2'd3, 1'b0},  // R4 region 1 over main memory
    {32'h00E8_0000, 4'h6, 1'b0, 2'd3, 1'b0},  // R4 region 2 over hole
    {32'h0300_0000, 4'h6, 1'b0, 2'd2, 1'b0},  // R4 empty region 3
    {32'h000C_1000, 4'h6, 1'b0, 2'd1, 1'b0},  // R2 segment 8 read on
    {32'h000C_1000, 4'h7, 1'b0, 2'd2, 1'b0},  // R3 segment 8 write off
    {32'h000A_0000, 4'hE, 1'b0, 2'd2, 1'b0},  // R3 segment 0 read off
    {32'h0000_0020, 4'h2, 1'b0, 2'd1, 1'b1},  // R7 interrupt controller
    {32'h0000_01F0, 4'h3, 1'b0, 2'd3, 1'b0},  // R7 disk range disabled
    {32'h0000_0078, 4'h2, 1'b0, 2'd1, 1'b0},  // R6 timer register
    {32'h0000_0300, 4'h2, 1'b0, 2'd3, 1'b0},  // R7 other I/O
    {32'h0100_0000, 4'hC, 1'b0, 2'd2, 1'b0},  // R5 read multiple
    {32'h0000_0000, 4'h0, 1'b0, 2'd0, 1'b0}   // R9 other command
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [2:0] slots(input logic [1:0] c);
    case (c)
      2'd1: slots = 3'b111;
      2'd2: slots = 3'b110;
      2'd3: slots = 3'b100;
      default: slots = 3'b000;
    endcase
  endfunction

  task automatic txn(input logic [31:0] a, input logic [3:0] c, input logic id,
                     input logic oth, output logic [1:0] cl1, output logic [2:0] dv,
                     output logic bc, output logic rt, output logic [1:0] cl3);
    @(negedge clk); addr_i = a; cmd_i = c; idsel_i = id; frame_i = 1'b1;
    @(negedge clk); cl1 = claim_o; dv[0] = devsel_o; bc = bcast_o; rt = retry_o;
    addr_i = 32'h0; cmd_i = 4'h0; idsel_i = 1'b0;
    if (oth) other_devsel_i = 1'b1;
    @(negedge clk); dv[1] = devsel_o; other_devsel_i = 1'b0;
    @(negedge clk); dv[2] = devsel_o; cl3 = claim_o; trn_end_i = 1'b1; frame_i = 1'b0;
    @(negedge clk); trn_end_i = 1'b0;
  endtask

  initial begin
    logic [1:0] cl1, cl3;
    logic [2:0] dv;
    logic bc, rt;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(claim_o == 2'd0, "R12 claim in reset", claim_o, 0);
    chk(!devsel_o && !bcast_o && !retry_o, "R12 flags in reset",
        {devsel_o, bcast_o, retry_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] e;
      e = VEC[i];
      txn(e[39:8], e[7:4], e[3], 1'b0, cl1, dv, bc, rt, cl3);
      chk(cl1 == e[2:1], $sformatf("row %0d claim class", i), cl1, e[2:1]);
      chk(bc == e[0], $sformatf("row %0d R7 broadcast", i), bc, e[0]);
      chk(dv == slots(e[2:1]), $sformatf("row %0d R10 devsel slots", i), dv, slots(e[2:1]));
      chk(cl3 == e[2:1], $sformatf("row %0d R9 held claim", i), cl3, e[2:1]);
      chk(rt == 1'b0, $sformatf("row %0d R8 idle bus no retry", i), rt, 0);
    end

    // R5 / R3 / R4 with negative decode off
    neg_en_i = 1'b0;
    txn(32'h0100_0000, 4'h6, 1'b0, 1'b0, cl1, dv, bc, rt, cl3);
    chk(cl1 == 2'd3, "R5 top with neg off", cl1, 3);
    chk(dv == 3'b100, "R10 slow slot", dv, 3'b100);
    txn(32'h000C_1000, 4'h7, 1'b0, 1'b0, cl1, dv, bc, rt, cl3);
    chk(cl1 == 2'd3, "R3 disabled write with neg off", cl1, 3);
    txn(32'h0205_0000, 4'h7, 1'b0, 1'b0, cl1, dv, bc, rt, cl3);
    chk(cl1 == 2'd3, "R4 region with neg off", cl1, 3);
    neg_en_i = 1'b1;

    // R6 timer decode off
    bt_en_i = 1'b0;
    txn(32'h0000_0078, 4'h3, 1'b0, 1'b0, cl1, dv, bc, rt, cl3);
    chk(cl1 == 2'd3, "R6 timer disabled", cl1, 3);
    bt_en_i = 1'b1;

    // R8 retry while expansion bus busy
    ebus_busy_i = 1'b1;
    txn(32'h0000_00A1, 4'h2, 1'b0, 1'b0, cl1, dv, bc, rt, cl3);
    chk(rt == 1'b1, "R8 busy broadcast retry", rt, 1);
    txn(32'h0000_0078, 4'h2, 1'b0, 1'b0, cl1, dv, bc, rt, cl3);
    chk(rt == 1'b0, "R8 busy non-broadcast", rt, 0);
    ide_en_i = 1'b1;
    txn(32'h0000_03F7, 4'h3, 1'b0, 1'b0, cl1, dv, bc, rt, cl3);
    chk(cl1 == 2'd1 && bc, "R7 disk range enabled", {cl1, bc}, 3'b011);
    chk(rt == 1'b1, "R8 disk broadcast retry", rt, 1);
    ebus_busy_i = 1'b0;

    // R11 another agent answers before slow slot
    txn(32'h0000_0300, 4'h2, 1'b0, 1'b1, cl1, dv, bc, rt, cl3);
    chk(cl1 == 2'd3, "R11 claim still subtractive", cl1, 3);
    chk(dv == 3'b000, "R11 devsel suppressed", dv, 0);
    txn(32'h0100_0000, 4'h6, 1'b0, 1'b1, cl1, dv, bc, rt, cl3);
    chk(dv == 3'b110, "R10 negative ignores other agent", dv, 3'b110);

    // R9 cleared after end
    @(negedge clk);
    chk(claim_o == 2'd0 && !devsel_o, "R9 cleared after end", {claim_o, devsel_o}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule